// File: doc/BRIEF.md
# Byte-Parity Guarded Local Memory

This block sits between a 32-bit local bus master and an on-chip RAM that keeps one extra bit for each data byte. On every write it computes an odd parity bit for each byte lane being written and stores it next to the data. On every read it recomputes the parity of each enabled byte lane from the stored data and compares it with the stored bit. The read data goes back to the master unchanged and with no added latency, whether or not the check fails.

A small register port holds a per-lane "corrupt parity" control that software uses to plant faults on purpose. It also holds an interrupt enable, a sticky parity-error flag cleared by writing 1, and a capture of the first failing word address and failing lanes. Diagnostics use the corrupt control to prove that both the parity generator and the checker work, lane by lane. Normal software leaves the control at zero and treats the interrupt as a memory fault.

Top module: `parity_guard_mem`

## Requirements
- R1: With no lane corruption selected, a word written with any data pattern, including every one of the 32 single-bit patterns, reads back with its written value and leaves the error flag clear. Stored parity is odd: a byte and its parity bit together hold an odd number of ones.
- R2: A read request (`bus_req`=1, `bus_we`=0) sampled at a clock edge gives `bus_rdata` and `bus_rvalid`=1 in the cycle after that edge. `bus_rvalid` is 0 in every other cycle.
- R3: Register 0 bits [3:0] each select one byte lane (bit n is data bits 8n+7..8n). A write with the bit for lane n set stores inverted parity for lane n only. A later read of that word with lane n enabled sets the error flag, with only bit n set in the failing-lane mask.
- R4: A read checks only the byte lanes enabled by `bus_be` on that read. A corrupt lane that is not enabled raises no error.
- R5: A write changes data and parity only in the lanes enabled by `bus_be`. Lanes not enabled keep both their data and their stored parity.
- R6: The error flag is register 1 bit 0. It is set in the cycle after the failing read data is presented. It stays set until a register 1 write with bit 0 equal to 1, and a write with bit 0 equal to 0 leaves it set.
- R7: Register 0 bit 8 enables the interrupt. `err_irq` equals the error flag ANDed with that enable, and it changes in the same cycle as the flag and the enable bit.
- R8: On an error while the flag is clear, the word address goes to register 2 and the failing-lane mask goes to register 1 bits [7:4]. Later errors do not change them while the flag stays set.
- R9: Read data is passed through unmodified even when the parity check fails.
- R10: After reset, registers 0, 1 and 2 read as 0, `err_irq` is 0 and `bus_rvalid` is 0.
- R11: If a failing read and a clear of the error flag land in the same cycle, the flag stays set and the new address and lane mask are captured.
- R12: A register read returns the register selected by `reg_addr` one cycle after the address is presented. Register 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| err_irq | output | 1 | Parity error interrupt |

## Verification
The hardest case to reach is a failing read whose data cycle is the same cycle as the software clear of the error flag. Getting there needs a word that was stored with corrupt parity, a flag that is already set from an earlier failure, and a register write timed to land on the exact cycle when `bus_rvalid` is high. The stimulus plants two corrupt words on different lanes, reads the first to set the flag and fill the capture, and then issues the second read. It presents the clear strobe right after the read edge, so the clear and the new failure meet at the same clock edge. A second failure while the flag is set, with no clear, is also driven to show that the capture holds.

// File: rtl/pg_pkg.sv
`timescale 1ns/100ps
package pg_pkg;
  localparam int LANE_W = 8;

  // odd parity bit: byte plus this bit holds an odd count of ones
  function automatic logic odd_bit(input logic [LANE_W-1:0] b);
    return ~(^b);
  endfunction

  // 1 when a byte and its stored bit do not form odd parity
  function automatic logic lane_bad(input logic [LANE_W-1:0] b, input logic p);
    return ~(^{p, b});
  endfunction
endpackage

// File: rtl/pg_parity_gen.sv
`timescale 1ns/100ps
module pg_parity_gen
  import pg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         corrupt,
  output logic [LANES-1:0]         wpar
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb wpar[g] = odd_bit(wdata[g*LANE_W +: LANE_W]) ^ corrupt[g];

    // R1: a lane with no corruption selected always forms odd parity
    a_r1_clean_lane_odd: assert property (@(posedge clk) disable iff (rst)
      !corrupt[g] |-> (^{wpar[g], wdata[g*LANE_W +: LANE_W]}) == 1'b1);
  end
endmodule

// File: rtl/pg_store.sv
`timescale 1ns/100ps
module pg_store
  import pg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         be,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         wpar,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [LANES-1:0]         rpar,
  output logic [LANES-1:0]         rbe,
  output logic [ADDR_W-1:0]        raddr,
  output logic                     rvalid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int COL_W = LANE_W + 1;

  logic rd_go;
  assign rd_go = req && !we;

  // one column per byte lane: parity bit sits on top of the byte
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [COL_W-1:0] mem [DEPTH];
    logic [COL_W-1:0] q;

    always_ff @(posedge clk) begin
      if (req && we && be[g]) mem[addr] <= {wpar[g], wdata[g*LANE_W +: LANE_W]};
      if (rd_go) q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q[LANE_W-1:0];
    assign rpar[g] = q[LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rbe    <= '0;
      raddr  <= '0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) begin
        rbe   <= be;
        raddr <= addr;
      end
    end
  end

  // R2: a read request is answered in the next cycle, and only then
  a_r2_read_answered: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> rvalid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> !rvalid);
endmodule

// File: rtl/pg_check.sv
`timescale 1ns/100ps
module pg_check
  import pg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     rvalid,
  input  logic [LANES*LANE_W-1:0]  rdata,
  input  logic [LANES-1:0]         rpar,
  input  logic [LANES-1:0]         rbe,
  output logic [LANES-1:0]         bad_lanes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb
      bad_lanes[g] = rvalid && rbe[g] && lane_bad(rdata[g*LANE_W +: LANE_W], rpar[g]);
  end
endmodule

// File: rtl/pg_regs.sv
`timescale 1ns/100ps
module pg_regs #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [LANES-1:0]   bad_lanes,
  input  logic [ADDR_W-1:0]  bad_addr,
  output logic [LANES-1:0]   corrupt,
  output logic               err_irq
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam int EN_BIT   = 8;
  localparam int MASK_LSB = 4;

  logic              irq_en, flag;
  logic [LANES-1:0]  fail_mask;
  logic [ADDR_W-1:0] fail_addr;

  logic ctrl_wr, clr, hit, flag_nx, en_nx, capture;
  logic unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign clr     = reg_wr && (reg_addr == SEL_STAT) && reg_wdata[0];
  assign hit     = |bad_lanes;
  assign flag_nx = hit || (flag && !clr);
  assign en_nx   = ctrl_wr ? reg_wdata[EN_BIT] : irq_en;
  assign capture = hit && (!flag || clr);
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      corrupt   <= '0;
      irq_en    <= 1'b0;
      flag      <= 1'b0;
      fail_mask <= '0;
      fail_addr <= '0;
      err_irq   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        corrupt <= reg_wdata[LANES-1:0];
        irq_en  <= reg_wdata[EN_BIT];
      end
      flag    <= flag_nx;
      err_irq <= flag_nx && en_nx;
      if (capture) begin
        fail_mask <= bad_lanes;
        fail_addr <= bad_addr;
      end else if (clr) begin
        fail_mask <= '0;
        fail_addr <= '0;
      end
      reg_rdata <= '0;
      case (reg_addr)
        SEL_CTRL: begin
          reg_rdata[LANES-1:0] <= corrupt;
          reg_rdata[EN_BIT]    <= irq_en;
        end
        SEL_STAT: begin
          reg_rdata[0] <= flag;
          reg_rdata[MASK_LSB +: LANES] <= fail_mask;
        end
        SEL_ADDR: reg_rdata[ADDR_W-1:0] <= fail_addr;
        default:  ;
      endcase
    end
  end

  // R6: the flag holds until an explicit clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag);
  // R3: any failing lane sets the flag at the next edge
  a_r3_failure_sets_flag: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R7: the interrupt never stands without the flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> flag);
  // R8: capture holds while the flag stays set and nothing clears it
  a_r8_capture_holds: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> $stable(fail_addr) && $stable(fail_mask));
endmodule

// File: rtl/parity_guard_mem.sv
`timescale 1ns/100ps
module parity_guard_mem
  import pg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [LANES-1:0]   bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               err_irq
);
  logic [LANES-1:0]  wpar, rpar, rbe, bad_lanes, corrupt;
  logic [ADDR_W-1:0] raddr;

  pg_parity_gen #(.LANES(LANES)) i_gen (
    .clk(clk), .rst(rst), .wdata(bus_wdata), .corrupt(corrupt), .wpar(wpar)
  );

  pg_store #(.ADDR_W(ADDR_W), .LANES(LANES)) i_store (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .wpar(wpar), .rdata(bus_rdata),
    .rpar(rpar), .rbe(rbe), .raddr(raddr), .rvalid(bus_rvalid)
  );

  pg_check #(.LANES(LANES)) i_check (
    .rvalid(bus_rvalid), .rdata(bus_rdata), .rpar(rpar), .rbe(rbe),
    .bad_lanes(bad_lanes)
  );

  pg_regs #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bad_lanes(bad_lanes),
    .bad_addr(raddr), .corrupt(corrupt), .err_irq(err_irq)
  );
endmodule

// File: tb/test_parity_guard_mem.sv
`timescale 1ns/100ps
module test_parity_guard_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_guard_mem i_parity_guard_mem (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_irq(err_irq)
  );

  // {data, corruption lanes, expected failing-lane mask}
  localparam logic [39:0] VEC [8] = '{
    {32'h0000_0001, 4'b0000, 4'b0000},
    {32'h0000_8000, 4'b0000, 4'b0000},
    {32'h0040_0000, 4'b0000, 4'b0000},
    {32'h8000_0000, 4'b0000, 4'b0000},
    {32'h0000_0001, 4'b0001, 4'b0001},
    {32'h0000_0200, 4'b0010, 4'b0010},
    {32'h00FF_0000, 4'b0100, 4'b0100},
    {32'h1234_5678, 4'b1001, 4'b1001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic mem_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // returns read data and the rvalid level one and two cycles later
  task automatic mem_read(input logic [7:0] a, input logic [3:0] be,
                          output logic [31:0] d, output logic v1, output logic v2);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; v1 = bus_rvalid;
    bus_req = 1'b0;
    @(posedge clk); @(negedge clk);
    v2 = bus_rvalid;
  endtask

  function automatic logic [31:0] stat(input logic f, input logic [3:0] m);
    return {24'd0, m, 3'd0, f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v1, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk("R10 irq", {31'd0, err_irq}, 32'd0);
    chk("R10 rvalid", {31'd0, bus_rvalid}, 32'd0);
    reg_read(2'd0, d); chk("R10 ctrl", d, 32'd0);
    reg_read(2'd1, d); chk("R10 status", d, 32'd0);
    reg_read(2'd2, d); chk("R10 fail addr", d, 32'd0);
    reg_read(2'd3, d); chk("R12 reg3 zero", d, 32'd0);

    // R2: read timing
    mem_write(8'd5, 4'hF, 32'hCAFE_F00D);
    mem_read(8'd5, 4'hF, d, v1, v2);
    chk("R2 data", d, 32'hCAFE_F00D);
    chk("R2 valid next cycle", {31'd0, v1}, 32'd1);
    chk("R2 valid drops", {31'd0, v2}, 32'd0);

    // table: R1 clean patterns, R3 per-lane corruption, R9 pass-through
    foreach (VEC[i]) begin
      reg_write(2'd1, 32'd1);
      reg_write(2'd0, {23'd0, 1'b1, 4'd0, VEC[i][7:4]});
      mem_write(8'(i + 32), 4'hF, VEC[i][39:8]);
      reg_write(2'd0, 32'h100);
      mem_read(8'(i + 32), 4'hF, d, v1, v2);
      chk("R9 table data", d, VEC[i][39:8]);
      reg_read(2'd1, d);
      chk("R3 table status", d, stat(VEC[i][3:0] != 0, VEC[i][3:0]));
    end
    reg_write(2'd1, 32'd1);
    reg_write(2'd0, 32'd0);

    // R1: all single-bit patterns clean
    for (int b = 0; b < 32; b++) begin
      mem_write(8'd64, 4'hF, 32'd1 << b);
      mem_read(8'd64, 4'hF, d, v1, v2);
      chk("R1 walk data", d, 32'd1 << b);
      chk("R1 walk no irq", {31'd0, err_irq}, 32'd0);
    end
    reg_read(2'd1, d); chk("R1 walk status", d, 32'd0);

    // R4: corrupt lane 2, read with lane 2 off then on
    reg_write(2'd0, 32'h4);
    mem_write(8'd10, 4'hF, 32'hAABB_CCDD);
    reg_write(2'd0, 32'h0);
    mem_read(8'd10, 4'b1011, d, v1, v2);
    reg_read(2'd1, d); chk("R4 disabled lane ignored", d, 32'd0);
    mem_read(8'd10, 4'b0100, d, v1, v2);
    chk("R9 data on failure", d, 32'hAABB_CCDD);
    reg_read(2'd1, d); chk("R4 enabled lane checked", d, stat(1'b1, 4'b0100));
    reg_write(2'd1, 32'd1);

    // R5: partial writes touch only enabled lanes
    mem_write(8'd10, 4'b0100, 32'h00EE_0000);
    reg_write(2'd0, 32'h1);
    mem_write(8'd10, 4'b0010, 32'h0000_1100);
    reg_write(2'd0, 32'h0);
    mem_read(8'd10, 4'hF, d, v1, v2);
    chk("R5 merged data", d, 32'hAAEE_11DD);
    reg_read(2'd1, d); chk("R5 no stray corruption", d, 32'd0);

    // R6/R7/R8: interrupt gating, sticky flag, capture hold
    reg_write(2'd0, 32'h2);
    mem_write(8'd20, 4'hF, 32'h0102_0304);
    reg_write(2'd0, 32'h8);
    mem_write(8'd21, 4'hF, 32'h0506_0708);
    reg_write(2'd0, 32'h0);
    mem_read(8'd20, 4'hF, d, v1, v2);
    chk("R7 irq masked", {31'd0, err_irq}, 32'd0);
    reg_write(2'd0, 32'h100);
    chk("R7 irq follows enable", {31'd0, err_irq}, 32'd1);
    mem_read(8'd21, 4'hF, d, v1, v2);
    reg_read(2'd2, d); chk("R8 first addr held", d, 32'd20);
    reg_read(2'd1, d); chk("R8 first mask held", d, stat(1'b1, 4'b0010));
    reg_write(2'd1, 32'd0);
    reg_read(2'd1, d); chk("R6 zero write keeps flag", d, stat(1'b1, 4'b0010));

    // R11: clear coinciding with a new failure
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'd21; bus_be = 4'hF;
    @(posedge clk); @(negedge clk);
    bus_req = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk("R11 irq stays", {31'd0, err_irq}, 32'd1);
    reg_read(2'd1, d); chk("R11 flag and new mask", d, stat(1'b1, 4'b1000));
    reg_read(2'd2, d); chk("R11 new addr", d, 32'd21);

    reg_write(2'd1, 32'd1);
    chk("R6 clear drops irq", {31'd0, err_irq}, 32'd0);
    reg_read(2'd1, d); chk("R6 cleared", d, 32'd0);
    reg_read(2'd0, d); chk("R12 ctrl readback", d, 32'h100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule